// File: doc/BRIEF.md
# Register Scoreboard with Writeback Arbiter

This block sits beside an in-order issue stage of a multi-warp core. It records which destination registers have an instruction in flight. Each new instruction is checked against those records for read-after-write and write-after-write hazards, and the block grants or stalls the instruction in the same cycle. Integer and floating-point records are kept separately for each warp. The vector records are a single set that every warp shares.

The same block decides which unit uses the single register-file write port. An arithmetic result always wins over a load result. A load that loses keeps its result and stays stalled. A store leaves the load/store path without using the port. When a result is written back, the block releases its destination records. The issue check in that cycle already sees the release.

An instruction carries seven source slots and three destination slots, each with its own valid flag.
- Source slots 0–1 are integer, slots 2–4 are floating-point and slots 5–6 are vector.
- Destination slot 0 is integer, slot 1 is floating-point and slot 2 is vector.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset no register is pending, so any instruction presented is granted. Neither writeback grant is asserted while no unit reports a result.
- R2: An instruction is stalled (issueStall=1, issueGrant=0) when any source slot with its valid flag set names a pending register of its own type. For integer and floating-point slots the register must also be pending for the issuing warp.
- R3: An instruction is stalled when any destination slot with its valid flag set names a register that is still pending (write-after-write).
- R4: Integer register index 0 is never made pending and never causes a stall. Floating-point and vector index 0 are tracked like any other index.
- R5: Integer and floating-point pending state is separate for each warp. Vector pending state is shared by all warps.
- R6: When an instruction is granted, every destination slot with its valid flag set becomes pending, starting from the next cycle.
- R7: A granted writeback releases the destination registers of the retiring result. The issue check in that same cycle already treats them as released.
- R8: When an arithmetic result and a load result that both carry a destination are presented in the same cycle, the arithmetic result gets the port (aluWbGrant=1). The load is refused (lsuWbGrant=0, lsuHold=1) and its registers stay pending.
- R9: A store completion (lsuDoneIsStore=1) never takes the write port, never raises lsuHold and releases nothing.
- R10: A memory-class instruction (issueIsMem=1) is stalled while lsuBusy=1 or lsuHold=1. An arithmetic-class instruction is not affected by either signal.
- R11: A source slot whose valid flag is clear is ignored, even when its index names a pending register.
- R12: A completion with no destination valid flag set does not claim the port, so a load presented in the same cycle is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented for issue |
| issueWarp | input | WARP_W | Warp of the presented instruction |
| issueIsMem | input | 1 | Instruction belongs to the memory class |
| issueSrc | input | 7 x REG_W | Source indices (slots 0-1 integer, 2-4 float, 5-6 vector) |
| issueSrcVld | input | 7 | Valid flag for each source slot |
| issueDst | input | 3 x REG_W | Destination indices (slot 0 integer, 1 float, 2 vector) |
| issueDstVld | input | 3 | Valid flag for each destination slot |
| issueGrant | output | 1 | Instruction issues this cycle |
| issueStall | output | 1 | Instruction is presented but held |
| lsuBusy | input | 1 | Load/store unit is still waiting on memory |
| aluDoneValid | input | 1 | Arithmetic unit presents a completion |
| aluDoneWarp | input | WARP_W | Warp of the arithmetic completion |
| aluDst | input | 3 x REG_W | Destination indices of the arithmetic completion |
| aluDstVld | input | 3 | Destination valid flags of the arithmetic completion |
| lsuDoneValid | input | 1 | Load/store unit presents a completion |
| lsuDoneIsStore | input | 1 | That completion is a store |
| lsuDoneWarp | input | WARP_W | Warp of the load/store completion |
| lsuDst | input | 3 x REG_W | Destination indices of the load completion |
| lsuDstVld | input | 3 | Destination valid flags of the load completion |
| aluWbGrant | output | 1 | Arithmetic result is written back this cycle |
| lsuWbGrant | output | 1 | Load result is written back this cycle |
| lsuHold | output | 1 | Load result was refused and must be held |

## Verification
The assertions assume that issueWarp, aluDoneWarp and lsuDoneWarp stay below the warp count. They also assume that a completion names only registers its own instruction made pending. The bench follows both rules: every writeback it presents releases a register that one of its own earlier issues marked, or a register that was not pending at all. A completion and an issue never mark and release the same register in one cycle, except in the bypass scenario, where the release is the event under test.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int INT_SRCS  = 2;
  localparam int FLT_SRCS  = 3;
  localparam int VEC_SRCS  = 2;
  localparam int FLT_BASE  = INT_SRCS;
  localparam int VEC_BASE  = INT_SRCS + FLT_SRCS;
  localparam int SRC_SLOTS = INT_SRCS + FLT_SRCS + VEC_SRCS;
  localparam int DST_INT   = 0;
  localparam int DST_FLT   = 1;
  localparam int DST_VEC   = 2;
  localparam int DST_SLOTS = 3;

  // strobes from control to the busy-bit datapath
  typedef struct packed {
    logic clrAlu;
    logic clrLsu;
  } wbStrobe_t;
endpackage

// File: rtl/sb_busy_dp.sv
module sb_busy_dp
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int WARP_W    = 2,
  parameter int REG_W     = 5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  wbStrobe_t                           wbStb,
  input  logic                                markEn,
  input  logic [WARP_W-1:0]                   issueWarp,
  input  logic [SRC_SLOTS-1:0][REG_W-1:0]     issueSrc,
  input  logic [SRC_SLOTS-1:0]                issueSrcVld,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]     issueDst,
  input  logic [DST_SLOTS-1:0]                issueDstVld,
  input  logic [WARP_W-1:0]                   aluDoneWarp,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]     aluDst,
  input  logic [DST_SLOTS-1:0]                aluDstVld,
  input  logic [WARP_W-1:0]                   lsuDoneWarp,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]     lsuDst,
  input  logic [DST_SLOTS-1:0]                lsuDstVld,
  output logic                                hazard
);
  logic [NUM_REGS-1:0] intBusy  [NUM_WARPS];
  logic [NUM_REGS-1:0] fltBusy  [NUM_WARPS];
  logic [NUM_REGS-1:0] vecBusy;
  logic [NUM_REGS-1:0] intAfter [NUM_WARPS];
  logic [NUM_REGS-1:0] fltAfter [NUM_WARPS];
  logic [NUM_REGS-1:0] vecAfter;

  // writeback release applied first, so issue sees it in the same cycle
  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      intAfter[w] = intBusy[w];
      fltAfter[w] = fltBusy[w];
    end
    vecAfter = vecBusy;
    if (wbStb.clrAlu) begin
      if (aluDstVld[DST_INT]) intAfter[aluDoneWarp][aluDst[DST_INT]] = 1'b0;
      if (aluDstVld[DST_FLT]) fltAfter[aluDoneWarp][aluDst[DST_FLT]] = 1'b0;
      if (aluDstVld[DST_VEC]) vecAfter[aluDst[DST_VEC]] = 1'b0;
    end
    if (wbStb.clrLsu) begin
      if (lsuDstVld[DST_INT]) intAfter[lsuDoneWarp][lsuDst[DST_INT]] = 1'b0;
      if (lsuDstVld[DST_FLT]) fltAfter[lsuDoneWarp][lsuDst[DST_FLT]] = 1'b0;
      if (lsuDstVld[DST_VEC]) vecAfter[lsuDst[DST_VEC]] = 1'b0;
    end
  end

  // source (RAW) and destination (WAW) lookups
  always_comb begin
    hazard = 1'b0;
    for (int s = 0; s < INT_SRCS; s++)
      if (issueSrcVld[s] && (issueSrc[s] != '0) && intAfter[issueWarp][issueSrc[s]])
        hazard = 1'b1;
    for (int s = FLT_BASE; s < FLT_BASE + FLT_SRCS; s++)
      if (issueSrcVld[s] && fltAfter[issueWarp][issueSrc[s]])
        hazard = 1'b1;
    for (int s = VEC_BASE; s < VEC_BASE + VEC_SRCS; s++)
      if (issueSrcVld[s] && vecAfter[issueSrc[s]])
        hazard = 1'b1;
    if (issueDstVld[DST_INT] && (issueDst[DST_INT] != '0) &&
        intAfter[issueWarp][issueDst[DST_INT]])
      hazard = 1'b1;
    if (issueDstVld[DST_FLT] && fltAfter[issueWarp][issueDst[DST_FLT]])
      hazard = 1'b1;
    if (issueDstVld[DST_VEC] && vecAfter[issueDst[DST_VEC]])
      hazard = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        intBusy[w] <= '0;
        fltBusy[w] <= '0;
      end
      vecBusy <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        intBusy[w] <= intAfter[w];
        fltBusy[w] <= fltAfter[w];
      end
      vecBusy <= vecAfter;
      if (markEn) begin
        if (issueDstVld[DST_INT] && (issueDst[DST_INT] != '0))
          intBusy[issueWarp][issueDst[DST_INT]] <= 1'b1;
        if (issueDstVld[DST_FLT])
          fltBusy[issueWarp][issueDst[DST_FLT]] <= 1'b1;
        if (issueDstVld[DST_VEC])
          vecBusy[issueDst[DST_VEC]] <= 1'b1;
      end
    end
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : gZeroChk
    assert_int_zero_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
      !intBusy[w][0]);
  end

  assert_mark_flt_R6: assert property (@(posedge clk) disable iff (!rstN)
    markEn && issueDstVld[DST_FLT] |=>
      fltBusy[$past(issueWarp)][$past(issueDst[DST_FLT])]);

  assert_mark_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    markEn && issueDstVld[DST_VEC] |=> vecBusy[$past(issueDst[DST_VEC])]);

  assert_release_vec_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbStb.clrAlu && aluDstVld[DST_VEC] &&
    !(markEn && issueDstVld[DST_VEC] && issueDst[DST_VEC] == aluDst[DST_VEC])
      |=> !vecBusy[$past(aluDst[DST_VEC])]);

  assert_no_mark_on_hazard_R2: assert property (@(posedge clk) disable iff (!rstN)
    hazard |-> !markEn);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic                  issueIsMem,
  input  logic                  hazard,
  input  logic                  lsuBusy,
  input  logic                  aluDoneValid,
  input  logic [DST_SLOTS-1:0]  aluDstVld,
  input  logic                  lsuDoneValid,
  input  logic                  lsuDoneIsStore,
  input  logic [DST_SLOTS-1:0]  lsuDstVld,
  output wbStrobe_t             wbStb,
  output logic                  markEn,
  output logic                  issueGrant,
  output logic                  issueStall,
  output logic                  aluWbGrant,
  output logic                  lsuWbGrant,
  output logic                  lsuHold
);
  logic aluReq, lsuReq, memBlocked;

  assign aluReq     = aluDoneValid && (aluDstVld != '0);
  assign lsuReq     = lsuDoneValid && !lsuDoneIsStore && (lsuDstVld != '0);
  assign aluWbGrant = aluReq;
  assign lsuWbGrant = lsuReq && !aluReq;
  assign lsuHold    = lsuReq && aluReq;

  assign memBlocked = issueIsMem && (lsuBusy || lsuHold);
  assign issueGrant = issueValid && !hazard && !memBlocked;
  assign issueStall = issueValid && !issueGrant;

  assign markEn       = issueGrant;
  assign wbStb.clrAlu = aluWbGrant;
  assign wbStb.clrLsu = lsuWbGrant;

  assert_wb_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(aluWbGrant && lsuWbGrant));

  assert_alu_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    aluDoneValid && (aluDstVld != '0) && lsuDoneValid && !lsuDoneIsStore &&
    (lsuDstVld != '0) |-> aluWbGrant && lsuHold);

  assert_store_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    lsuDoneValid && lsuDoneIsStore |-> !lsuWbGrant && !lsuHold);

  assert_mem_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueIsMem && lsuBusy |-> !issueGrant);

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueGrant |-> issueValid && !issueStall);
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             issueValid,
  input  logic [WARP_W-1:0]                issueWarp,
  input  logic                             issueIsMem,
  input  logic [SRC_SLOTS-1:0][REG_W-1:0]  issueSrc,
  input  logic [SRC_SLOTS-1:0]             issueSrcVld,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]  issueDst,
  input  logic [DST_SLOTS-1:0]             issueDstVld,
  output logic                             issueGrant,
  output logic                             issueStall,
  input  logic                             lsuBusy,
  input  logic                             aluDoneValid,
  input  logic [WARP_W-1:0]                aluDoneWarp,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]  aluDst,
  input  logic [DST_SLOTS-1:0]             aluDstVld,
  input  logic                             lsuDoneValid,
  input  logic                             lsuDoneIsStore,
  input  logic [WARP_W-1:0]                lsuDoneWarp,
  input  logic [DST_SLOTS-1:0][REG_W-1:0]  lsuDst,
  input  logic [DST_SLOTS-1:0]             lsuDstVld,
  output logic                             aluWbGrant,
  output logic                             lsuWbGrant,
  output logic                             lsuHold
);
  wbStrobe_t wbStb;
  logic      markEn;
  logic      hazard;

  sb_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueIsMem(issueIsMem), .hazard(hazard),
    .lsuBusy(lsuBusy),
    .aluDoneValid(aluDoneValid), .aluDstVld(aluDstVld),
    .lsuDoneValid(lsuDoneValid), .lsuDoneIsStore(lsuDoneIsStore),
    .lsuDstVld(lsuDstVld),
    .wbStb(wbStb), .markEn(markEn),
    .issueGrant(issueGrant), .issueStall(issueStall),
    .aluWbGrant(aluWbGrant), .lsuWbGrant(lsuWbGrant), .lsuHold(lsuHold)
  );

  sb_busy_dp #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WARP_W(WARP_W), .REG_W(REG_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .wbStb(wbStb), .markEn(markEn),
    .issueWarp(issueWarp), .issueSrc(issueSrc), .issueSrcVld(issueSrcVld),
    .issueDst(issueDst), .issueDstVld(issueDstVld),
    .aluDoneWarp(aluDoneWarp), .aluDst(aluDst), .aluDstVld(aluDstVld),
    .lsuDoneWarp(lsuDoneWarp), .lsuDst(lsuDst), .lsuDstVld(lsuDstVld),
    .hazard(hazard)
  );
endmodule

// File: tb/reg_scoreboard_test.sv
`timescale 1ns/100ps
module reg_scoreboard_test;
  import sb_pkg::*;
  localparam int NW = 4;
  localparam int NR = 32;
  localparam int WW = 2;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid, issueIsMem, issueGrant, issueStall, lsuBusy;
  logic [WW-1:0] issueWarp, aluDoneWarp, lsuDoneWarp;
  logic [SRC_SLOTS-1:0][RW-1:0] issueSrc;
  logic [SRC_SLOTS-1:0] issueSrcVld;
  logic [DST_SLOTS-1:0][RW-1:0] issueDst, aluDst, lsuDst;
  logic [DST_SLOTS-1:0] issueDstVld, aluDstVld, lsuDstVld;
  logic aluDoneValid, lsuDoneValid, lsuDoneIsStore;
  logic aluWbGrant, lsuWbGrant, lsuHold;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  reg_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueWarp(issueWarp),
    .issueIsMem(issueIsMem), .issueSrc(issueSrc), .issueSrcVld(issueSrcVld),
    .issueDst(issueDst), .issueDstVld(issueDstVld), .issueGrant(issueGrant),
    .issueStall(issueStall), .lsuBusy(lsuBusy), .aluDoneValid(aluDoneValid),
    .aluDoneWarp(aluDoneWarp), .aluDst(aluDst), .aluDstVld(aluDstVld),
    .lsuDoneValid(lsuDoneValid), .lsuDoneIsStore(lsuDoneIsStore),
    .lsuDoneWarp(lsuDoneWarp), .lsuDst(lsuDst), .lsuDstVld(lsuDstVld),
    .aluWbGrant(aluWbGrant), .lsuWbGrant(lsuWbGrant), .lsuHold(lsuHold)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearInputs();
    issueValid = 0; issueIsMem = 0; issueWarp = '0;
    issueSrc = '0; issueSrcVld = '0; issueDst = '0; issueDstVld = '0;
    lsuBusy = 0; aluDoneValid = 0; aluDoneWarp = '0; aluDst = '0; aluDstVld = '0;
    lsuDoneValid = 0; lsuDoneIsStore = 0; lsuDoneWarp = '0; lsuDst = '0; lsuDstVld = '0;
  endtask

  // inputs change just after a falling edge; outputs are read 1 ns later
  task automatic nextCycle();
    @(negedge clk);
    clearInputs();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic issueOp(int warp, bit mem);
    issueValid = 1; issueWarp = WW'(warp); issueIsMem = mem;
  endtask

  task automatic useSrc(int slot, int idx);
    issueSrc[slot] = RW'(idx); issueSrcVld[slot] = 1;
  endtask

  task automatic useDst(int slot, int idx);
    issueDst[slot] = RW'(idx); issueDstVld[slot] = 1;
  endtask

  task automatic aluDone(int warp, int slot, int idx);
    aluDoneValid = 1; aluDoneWarp = WW'(warp);
    if (slot >= 0) begin aluDst[slot] = RW'(idx); aluDstVld[slot] = 1; end
  endtask

  task automatic lsuDone(int warp, bit store, int slot, int idx);
    lsuDoneValid = 1; lsuDoneIsStore = store; lsuDoneWarp = WW'(warp);
    if (slot >= 0) begin lsuDst[slot] = RW'(idx); lsuDstVld[slot] = 1; end
  endtask

  task automatic testReset();
    nextCycle();
    issueOp(0, 0); useSrc(1, 3); useSrc(FLT_BASE, 0); useSrc(VEC_BASE, 0);
    settle();
    check("R1 grant after reset", int'(issueGrant), 1);
    check("R1 no alu wb idle", int'(aluWbGrant), 0);
    check("R1 no lsu wb idle", int'(lsuWbGrant), 0);
  endtask

  task automatic testIntRaw();
    nextCycle(); issueOp(1, 0); useDst(DST_INT, 5); settle();
    check("R6 producer granted", int'(issueGrant), 1);
    nextCycle(); issueOp(1, 0); useSrc(1, 5); settle();
    check("R2 int raw stall", int'(issueStall), 1);
    check("R2 int raw no grant", int'(issueGrant), 0);
    nextCycle(); issueOp(2, 0); useSrc(0, 5); settle();
    check("R5 other warp int free", int'(issueGrant), 1);
    // same-cycle release bypass
    nextCycle(); issueOp(1, 0); useSrc(0, 5); aluDone(1, DST_INT, 5); settle();
    check("R7 bypass grant", int'(issueGrant), 1);
    check("R7 alu wb granted", int'(aluWbGrant), 1);
    nextCycle(); issueOp(1, 0); useSrc(1, 5); settle();
    check("R7 released next cycle", int'(issueGrant), 1);
  endtask

  task automatic testRegZero();
    nextCycle(); issueOp(0, 0); useDst(DST_INT, 0); useDst(DST_FLT, 0); settle();
    check("R4 zero dst granted", int'(issueGrant), 1);
    nextCycle(); issueOp(0, 0); useSrc(0, 0); settle();
    check("R4 int zero never pending", int'(issueGrant), 1);
    nextCycle(); issueOp(0, 0); useSrc(FLT_BASE + 1, 0); settle();
    check("R4 float zero tracked", int'(issueStall), 1);
    nextCycle(); aluDone(0, DST_FLT, 0); settle();
    check("R7 alu release float", int'(aluWbGrant), 1);
    nextCycle(); issueOp(0, 0); useSrc(FLT_BASE + 1, 0); settle();
    check("R7 float zero released", int'(issueGrant), 1);
  endtask

  task automatic testVecShared();
    nextCycle(); issueOp(0, 0); useDst(DST_VEC, 7); settle();
    check("R6 vec producer granted", int'(issueGrant), 1);
    nextCycle(); issueOp(3, 0); useSrc(VEC_BASE + 1, 7); settle();
    check("R5 vec shared stall", int'(issueStall), 1);
    nextCycle(); lsuDone(0, 0, DST_VEC, 7); settle();
    check("R7 load release vec", int'(lsuWbGrant), 1);
    nextCycle(); issueOp(3, 0); useSrc(VEC_BASE + 1, 7); settle();
    check("R7 vec released", int'(issueGrant), 1);
  endtask

  task automatic testWawAndInvalid();
    nextCycle(); issueOp(2, 0); useDst(DST_FLT, 9); settle();
    check("R6 float producer", int'(issueGrant), 1);
    nextCycle(); issueOp(2, 0); useDst(DST_FLT, 9); settle();
    check("R3 waw stall", int'(issueStall), 1);
    nextCycle(); issueOp(2, 0); issueSrc[FLT_BASE + 1] = RW'(9); settle();
    check("R11 invalid src ignored", int'(issueGrant), 1);
    nextCycle(); issueOp(2, 0); useSrc(FLT_BASE + 2, 9); settle();
    check("R2 float raw stall", int'(issueStall), 1);
    nextCycle(); aluDone(2, DST_FLT, 9); settle();
    nextCycle(); issueOp(2, 0); useDst(DST_FLT, 9); settle();
    check("R3 waw cleared", int'(issueGrant), 1);
    nextCycle(); aluDone(2, DST_FLT, 9); settle();
  endtask

  task automatic testArbitration();
    nextCycle(); issueOp(0, 1); useDst(DST_INT, 6); settle();
    check("R6 load producer", int'(issueGrant), 1);
    nextCycle(); issueOp(0, 0); useSrc(0, 6);
    aluDone(0, DST_INT, 4); lsuDone(0, 0, DST_INT, 6); settle();
    check("R8 alu wins", int'(aluWbGrant), 1);
    check("R8 load refused", int'(lsuWbGrant), 0);
    check("R8 load held", int'(lsuHold), 1);
    check("R8 loser not released", int'(issueStall), 1);
    nextCycle(); issueOp(1, 1); aluDone(0, DST_INT, 4); lsuDone(0, 0, DST_INT, 6); settle();
    check("R10 mem blocked by hold", int'(issueStall), 1);
    nextCycle(); issueOp(0, 0); useSrc(1, 6); lsuDone(0, 0, DST_INT, 6); settle();
    check("R8 load later granted", int'(lsuWbGrant), 1);
    check("R8 hold dropped", int'(lsuHold), 0);
    check("R7 load bypass", int'(issueGrant), 1);
  endtask

  task automatic testStore();
    nextCycle(); aluDone(1, DST_INT, 8); lsuDone(1, 1, -1, 0); issueOp(1, 1); settle();
    check("R9 store no port", int'(lsuWbGrant), 0);
    check("R9 store no hold", int'(lsuHold), 0);
    check("R9 alu unaffected", int'(aluWbGrant), 1);
    check("R10 mem issue during store", int'(issueGrant), 1);
  endtask

  task automatic testLsuBusy();
    nextCycle(); lsuBusy = 1; issueOp(3, 1); settle();
    check("R10 mem stalled busy", int'(issueStall), 1);
    nextCycle(); lsuBusy = 1; issueOp(3, 0); settle();
    check("R10 alu class unaffected", int'(issueGrant), 1);
  endtask

  task automatic testNoDestDone();
    nextCycle(); aluDone(2, -1, 0); lsuDone(2, 0, DST_FLT, 11); settle();
    check("R12 empty alu no port", int'(aluWbGrant), 0);
    check("R12 load granted", int'(lsuWbGrant), 1);
    check("R12 no hold", int'(lsuHold), 0);
  endtask

  initial begin
    clearInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIntRaw();
    testRegZero();
    testVecShared();
    testWawAndInvalid();
    testArbitration();
    testStore();
    testLsuBusy();
    testNoDestDone();
    nextCycle();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule